// File: doc/BRIEF.md
# Two-Way Cache Tag and LRU Controller

This block keeps the bookkeeping side of a two-way set-associative data cache with 32-byte lines and a 29-bit physical address. It stores one tag, one valid bit and one dirty bit per line, plus one replacement bit per set. A lookup is presented for one cycle. In the next cycle the block reports a hit or a miss, the way that hit, and the way that a refill would replace. It also raises a write-back request when that replacement line holds modified data.

The controller is given one fill port. The fill writes a new tag into a chosen way, marks the line present and clean, and moves the replacement bit. A write that hits in copy-back mode marks the line modified, and a write in write-through mode never does. There are two resets. Power-on reset wipes all presence, modified and replacement state. Manual reset keeps that state and only quiets the response path. The line data, the bus side and any software window onto the arrays belong to other blocks.

Top module: `cache_tag_lru2`

## Requirements
- R1: A lookup accepted in cycle N (req_valid high, both resets low) gives rsp_valid high with its result fields in cycle N+1. rsp_valid is low in every cycle that does not follow an accepted lookup.
- R2: The set index is address bits 13:5 and the tag is address bits 28:10. Bits 4:0 select a byte in the line, so addresses that differ only in those bits find the same line.
- R3: rsp_hit is 1 exactly when a way of the indexed set holds a present line whose stored tag equals the lookup tag. rsp_way names that way (0 or 1). A line that is not present never hits, whatever its stored tag.
- R4: When both ways of the set match, rsp_multi_hit is 1, rsp_hit is 1 and rsp_way is 0. Otherwise rsp_multi_hit is 0.
- R5: Each set has one replacement bit. A hit, or a fill, sets it to the way not accessed (1 after way 0, 0 after way 1). A miss leaves it unchanged.
- R6: rsp_victim reports the set's replacement bit as it was when the lookup was accepted. A value of 0 means way 0.
- R7: rsp_wb_req is 1 exactly when the lookup misses and the victim way holds a line that is both present and modified. rsp_victim_tag then gives that line's stored tag.
- R8: A write lookup (req_write=1) that hits marks the hit line modified when req_copy_back=1 (copy-back). It leaves the modified bit unchanged when req_copy_back=0 (write-through). A write that misses changes nothing.
- R9: A fill (fill_valid=1) stores tag bits 28:10 of fill_addr into way fill_way of set bits 13:5. It marks the line present and clears its modified bit.
- R10: When a lookup and a fill arrive in the same cycle, the lookup result reflects the state before the fill. If both touch the same set, the fill's replacement-bit and modified-bit updates override those of the lookup.
- R11: While por_rst is high, every present, modified and replacement bit clears, rsp_valid is low, and no lookup or fill takes effect.
- R12: While man_rst is high, rsp_valid is low and no lookup or fill takes effect. Present bits, modified bits, replacement bits and tags all keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| por_rst | input | 1 | Synchronous power-on reset, active high |
| man_rst | input | 1 | Synchronous manual reset, active high |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 29 | Lookup physical address |
| req_write | input | 1 | Lookup is a store |
| req_copy_back | input | 1 | 1 = copy-back policy, 0 = write-through |
| fill_valid | input | 1 | Fill request |
| fill_addr | input | 29 | Address of the line being filled |
| fill_way | input | 1 | Way receiving the fill |
| rsp_valid | output | 1 | Response valid, one cycle after the lookup |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 1 | Way that hit |
| rsp_multi_hit | output | 1 | Both ways matched (error) |
| rsp_victim | output | 1 | Way chosen for replacement |
| rsp_wb_req | output | 1 | Victim is present and modified, must be written back |
| rsp_victim_tag | output | 19 | Stored tag of the victim line |

## Verification
The bench builds the block with its default geometry: a 29-bit address, 5 offset bits, 9 index bits and a 19-bit tag. This puts both index extremes, set 0 and set 511, within reach, along with the all-ones tag. It also reproduces the overlap of tag bits 13:10 with the index, so the bench's own address model must agree with the block on which bits decide a set. At full depth, lookups of tag 0 right after power-on reset run against tags that were never written, which tests that a hit depends on the present bit.

// File: rtl/ctl2w_pkg.sv
package ctl2w_pkg;

    localparam int WAYS = 2;

    typedef enum logic {
        POLICY_WT = 1'b0,
        POLICY_CB = 1'b1
    } wr_policy_e;

    typedef struct packed {
        logic valid;
        logic dirty;
    } line_state_t;

    function automatic logic other_way(input logic w);
        return ~w;
    endfunction

    function automatic logic pick_hit_way(input logic [WAYS-1:0] m);
        return m[0] ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/ctl2w_way_store.sv
module ctl2w_way_store
    import ctl2w_pkg::*;
#(
    parameter int TAG_W = 19,
    parameter int SET_W = 9
) (
    input  logic             clk,
    input  logic             por_rst,
    input  logic [SET_W-1:0] rd_set,
    output logic [TAG_W-1:0] rd_tag,
    output line_state_t      rd_state,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             mark_en,
    input  logic [SET_W-1:0] mark_set
);

    localparam int SETS = 1 << SET_W;

    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;

    // Tags carry no reset: presence gates every hit.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_set] <= fill_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (por_rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (mark_en) begin
                dirty_q[mark_set] <= 1'b1;
            end
            // A fill comes last so it overrides a mark on the same line.
            if (fill_en) begin
                valid_q[fill_set] <= 1'b1;
                dirty_q[fill_set] <= 1'b0;
            end
        end
    end

    assign rd_tag         = tag_q[rd_set];
    assign rd_state.valid = valid_q[rd_set];
    assign rd_state.dirty = dirty_q[rd_set];

    AST_FILL_LEAVES_CLEAN: assert property (@(posedge clk) disable iff (por_rst)
        fill_en |=> (valid_q[$past(fill_set)] && !dirty_q[$past(fill_set)])); // R9

    AST_MARK_SETS_DIRTY: assert property (@(posedge clk) disable iff (por_rst)
        (mark_en && !(fill_en && fill_set == mark_set)) |=> dirty_q[$past(mark_set)]); // R8

    AST_POR_CLEARS_LINES: assert property (@(posedge clk)
        $past(por_rst) |-> (valid_q == '0 && dirty_q == '0)); // R11

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (por_rst)
        (!fill_en && !mark_en) |=> (valid_q == $past(valid_q) && dirty_q == $past(dirty_q))); // R12

endmodule

// File: rtl/ctl2w_lru_store.sv
module ctl2w_lru_store
    import ctl2w_pkg::*;
#(
    parameter int SET_W = 9
) (
    input  logic             clk,
    input  logic             por_rst,
    input  logic [SET_W-1:0] rd_set,
    output logic             rd_lru,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic             touch_way,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic             fill_way
);

    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            lru_q <= '0;
        end else begin
            if (touch_en) begin
                lru_q[touch_set] <= other_way(touch_way);
            end
            // Fill written last: it wins on a shared set.
            if (fill_en) begin
                lru_q[fill_set] <= other_way(fill_way);
            end
        end
    end

    assign rd_lru = lru_q[rd_set];

    AST_LRU_FILL_AWAY: assert property (@(posedge clk) disable iff (por_rst)
        fill_en |=> (lru_q[$past(fill_set)] == !$past(fill_way))); // R5

    AST_LRU_TOUCH_AWAY: assert property (@(posedge clk) disable iff (por_rst)
        (touch_en && !(fill_en && fill_set == touch_set))
            |=> (lru_q[$past(touch_set)] == !$past(touch_way))); // R5

    AST_LRU_POR_ZERO: assert property (@(posedge clk)
        $past(por_rst) |-> (lru_q == '0)); // R11

endmodule

// File: rtl/ctl2w_hit_detect.sv
module ctl2w_hit_detect
    import ctl2w_pkg::*;
#(
    parameter int TAG_W = 19
) (
    input  logic [TAG_W-1:0]           key,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0]            valid,
    output logic                       hit,
    output logic                       hit_way,
    output logic                       multi
);

    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == key);
    end

    assign hit     = |match;
    assign multi   = &match;
    assign hit_way = pick_hit_way(match);

endmodule

// File: rtl/cache_tag_lru2.sv
module cache_tag_lru2
    import ctl2w_pkg::*;
#(
    parameter int ADDR_W   = 29,
    parameter int OFFSET_W = 5,
    parameter int SET_W    = 9,
    parameter int TAG_W    = 19
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              man_rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_copy_back,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_way,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_way,
    output logic              rsp_multi_hit,
    output logic              rsp_victim,
    output logic              rsp_wb_req,
    output logic [TAG_W-1:0]  rsp_victim_tag
);

    localparam int TAG_LSB = ADDR_W - TAG_W;
    localparam int SET_LSB = OFFSET_W;

    typedef struct packed {
        logic             hit;
        logic             way;
        logic             multi;
        logic             victim;
        logic             wb;
        logic [TAG_W-1:0] vtag;
    } rsp_t;

    logic                       rst_any;
    logic                       lk_en;
    logic                       fl_en;
    logic [TAG_W-1:0]           lk_tag;
    logic [TAG_W-1:0]           fl_tag;
    logic [SET_W-1:0]           lk_set;
    logic [SET_W-1:0]           fl_set;
    wr_policy_e                 policy;
    logic [WAYS-1:0][TAG_W-1:0] way_tag;
    line_state_t [WAYS-1:0]     way_state;
    logic [WAYS-1:0]            way_valid;
    logic [WAYS-1:0]            way_fill_en;
    logic [WAYS-1:0]            way_mark_en;
    logic                       hit;
    logic                       hit_way;
    logic                       multi;
    logic                       lru_bit;
    line_state_t                vic_state;
    rsp_t                       rsp_d;
    rsp_t                       rsp_q;
    logic                       unused_offset_bits;

    assign rst_any = por_rst | man_rst;
    assign lk_en   = req_valid  & ~rst_any;
    assign fl_en   = fill_valid & ~rst_any;

    assign lk_tag = req_addr[TAG_LSB +: TAG_W];
    assign lk_set = req_addr[SET_LSB +: SET_W];
    assign fl_tag = fill_addr[TAG_LSB +: TAG_W];
    assign fl_set = fill_addr[SET_LSB +: SET_W];
    assign policy = wr_policy_e'(req_copy_back);

    assign unused_offset_bits = ^{req_addr[SET_LSB-1:0], fill_addr[SET_LSB-1:0]};

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_fill_en[w] = fl_en && (fill_way == 1'(w));
        assign way_mark_en[w] = lk_en && req_write && (policy == POLICY_CB)
                                && hit && (hit_way == 1'(w));
        assign way_valid[w]   = way_state[w].valid;

        ctl2w_way_store #(
            .TAG_W (TAG_W),
            .SET_W (SET_W)
        ) u_store (
            .clk      (clk),
            .por_rst  (por_rst),
            .rd_set   (lk_set),
            .rd_tag   (way_tag[w]),
            .rd_state (way_state[w]),
            .fill_en  (way_fill_en[w]),
            .fill_set (fl_set),
            .fill_tag (fl_tag),
            .mark_en  (way_mark_en[w]),
            .mark_set (lk_set)
        );
    end

    ctl2w_hit_detect #(
        .TAG_W (TAG_W)
    ) u_hit (
        .key     (lk_tag),
        .tags    (way_tag),
        .valid   (way_valid),
        .hit     (hit),
        .hit_way (hit_way),
        .multi   (multi)
    );

    ctl2w_lru_store #(
        .SET_W (SET_W)
    ) u_lru (
        .clk       (clk),
        .por_rst   (por_rst),
        .rd_set    (lk_set),
        .rd_lru    (lru_bit),
        .touch_en  (lk_en && hit),
        .touch_set (lk_set),
        .touch_way (hit_way),
        .fill_en   (fl_en),
        .fill_set  (fl_set),
        .fill_way  (fill_way)
    );

    assign vic_state = way_state[lru_bit];

    always_comb begin
        rsp_d.hit    = hit;
        rsp_d.way    = hit_way;
        rsp_d.multi  = multi;
        rsp_d.victim = lru_bit;
        rsp_d.wb     = !hit && vic_state.valid && vic_state.dirty;
        rsp_d.vtag   = way_tag[lru_bit];
    end

    always_ff @(posedge clk) begin
        if (rst_any) begin
            rsp_valid <= 1'b0;
            rsp_q     <= '0;
        end else begin
            rsp_valid <= lk_en;
            if (lk_en) begin
                rsp_q <= rsp_d;
            end
        end
    end

    assign rsp_hit        = rsp_q.hit;
    assign rsp_way        = rsp_q.way;
    assign rsp_multi_hit  = rsp_q.multi;
    assign rsp_victim     = rsp_q.victim;
    assign rsp_wb_req     = rsp_q.wb;
    assign rsp_victim_tag = rsp_q.vtag;

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (por_rst || man_rst)
        req_valid |=> rsp_valid); // R1

    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (por_rst || man_rst)
        !req_valid |=> !rsp_valid); // R1

    AST_WB_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (por_rst || man_rst)
        (rsp_valid && rsp_wb_req) |-> !rsp_hit); // R7

    AST_MULTI_TAKES_WAY0: assert property (@(posedge clk) disable iff (por_rst || man_rst)
        (rsp_valid && rsp_multi_hit) |-> (rsp_hit && !rsp_way)); // R4

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(por_rst || man_rst) |-> !rsp_valid); // R11 R12

endmodule

// File: tb/cache_tag_lru2_test.sv
module cache_tag_lru2_test;

    localparam int CLK_PERIOD = 10;
    localparam int NSETS      = 512;

    typedef struct {
        int          cyc;
        bit          hit;
        bit          way;
        bit          multi;
        bit          victim;
        bit          wb;
        bit [18:0]   vtag;
    } exp_t;

    logic        clk = 1'b0;
    logic        por_rst;
    logic        man_rst;
    logic        req_valid;
    logic [28:0] req_addr;
    logic        req_write;
    logic        req_copy_back;
    logic        fill_valid;
    logic [28:0] fill_addr;
    logic        fill_way;
    logic        rsp_valid;
    logic        rsp_hit;
    logic        rsp_way;
    logic        rsp_multi_hit;
    logic        rsp_victim;
    logic        rsp_wb_req;
    logic [18:0] rsp_victim_tag;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    exp_t      expq[$];
    bit [18:0] mt [2][NSETS];
    bit        mv [2][NSETS];
    bit        md [2][NSETS];
    bit        ml [NSETS];

    cache_tag_lru2 uut (
        .clk            (clk),
        .por_rst        (por_rst),
        .man_rst        (man_rst),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .req_write      (req_write),
        .req_copy_back  (req_copy_back),
        .fill_valid     (fill_valid),
        .fill_addr      (fill_addr),
        .fill_way       (fill_way),
        .rsp_valid      (rsp_valid),
        .rsp_hit        (rsp_hit),
        .rsp_way        (rsp_way),
        .rsp_multi_hit  (rsp_multi_hit),
        .rsp_victim     (rsp_victim),
        .rsp_wb_req     (rsp_wb_req),
        .rsp_victim_tag (rsp_victim_tag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string r, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", r, what, act, exp);
        end
    endtask

    function automatic logic [28:0] mk(input logic [18:0] t, input logic [4:0] slo, input logic [4:0] off);
        return {t, slo, off};
    endfunction

    function automatic int set_of(input logic [28:0] a);
        return int'(a[13:5]);
    endfunction

    function automatic bit [18:0] tag_of(input logic [28:0] a);
        return a[28:10];
    endfunction

    function automatic void model_por();
        for (int s = 0; s < NSETS; s++) begin
            mv[0][s] = 0; mv[1][s] = 0;
            md[0][s] = 0; md[1][s] = 0;
            ml[s]    = 0;
        end
    endfunction

    // Driver: one cycle of stimulus; expectation from the bench model.
    task automatic op(input bit lk, input logic [28:0] a, input bit wr, input bit cb,
                      input bit fl, input logic [28:0] fa, input bit fw);
        exp_t e;
        int   s;
        int   fs;
        bit   m0;
        bit   m1;
        @(negedge clk);
        req_valid     = lk;
        req_addr      = a;
        req_write     = wr;
        req_copy_back = cb;
        fill_valid    = fl;
        fill_addr     = fa;
        fill_way      = fw;
        if (lk) begin
            s        = set_of(a);
            m0       = mv[0][s] && (mt[0][s] == tag_of(a));
            m1       = mv[1][s] && (mt[1][s] == tag_of(a));
            e.cyc    = cyc;
            e.hit    = m0 | m1;
            e.way    = m0 ? 1'b0 : 1'b1;
            e.multi  = m0 & m1;
            e.victim = ml[s];
            e.wb     = !e.hit && mv[e.victim][s] && md[e.victim][s];
            e.vtag   = mt[e.victim][s];
            expq.push_back(e);
            if (e.hit) begin
                ml[s] = !e.way;
                if (wr && cb) md[e.way][s] = 1;
            end
        end
        if (fl) begin
            fs         = set_of(fa);
            mt[fw][fs] = tag_of(fa);
            mv[fw][fs] = 1;
            md[fw][fs] = 0;
            ml[fs]     = !fw;
        end
    endtask

    task automatic look(input logic [28:0] a, input bit wr, input bit cb);
        op(1, a, wr, cb, 0, '0, 0);
    endtask

    task automatic fill(input logic [28:0] fa, input bit fw);
        op(0, '0, 0, 0, 1, fa, fw);
    endtask

    task automatic idle();
        op(0, '0, 0, 0, 0, '0, 0);
    endtask

    task automatic do_por();
        @(negedge clk);
        req_valid = 0; fill_valid = 0; por_rst = 1;
        @(negedge clk);
        chk("R11", "rsp_valid during power-on reset", rsp_valid, 0);
        por_rst = 0;
        model_por();
    endtask

    task automatic do_man();
        @(negedge clk);
        req_valid = 0; fill_valid = 0; man_rst = 1;
        @(negedge clk);
        chk("R12", "rsp_valid during manual reset", rsp_valid, 0);
        man_rst = 0;
    endtask

    // Monitor: pops expectations as responses appear.
    always @(negedge clk) begin
        exp_t e;
        if (rsp_valid) begin
            if (expq.size() == 0) begin
                chk("R1", "unexpected rsp_valid", 1, 0);
            end else begin
                e = expq.pop_front();
                chk("R1", "response cycle", cyc, e.cyc + 1);
                chk("R3", "hit", rsp_hit, e.hit);
                if (e.hit) chk("R3", "hit way", rsp_way, e.way);
                chk("R4", "multi hit", rsp_multi_hit, e.multi);
                chk("R6", "victim", rsp_victim, e.victim);
                chk("R7", "wb_req", rsp_wb_req, e.wb);
                if (e.wb) chk("R7", "victim tag", rsp_victim_tag, e.vtag);
            end
        end else if (expq.size() > 0 && expq[0].cyc + 1 <= cyc) begin
            e = expq.pop_front();
            chk("R1", "missing response", 0, 1);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk("WATCHDOG", "run ended", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [28:0] a_A, a_B, a_C, a_D;
        por_rst = 1; man_rst = 0;
        req_valid = 0; req_addr = '0; req_write = 0; req_copy_back = 0;
        fill_valid = 0; fill_addr = '0; fill_way = 0;
        repeat (3) @(negedge clk);
        chk("R11", "rsp_valid after power-on", rsp_valid, 0);
        por_rst = 0;
        model_por();

        // R3: never-written tags in set 0 must not hit.
        look(mk(19'h0, 5'd0, 5'd0), 0, 0);
        look(mk(19'h7FFF0, 5'd0, 5'd9), 0, 0);

        // R2 R3 R5 R6: basic fills and hits in one set.
        a_A = mk(19'h12345, 5'd3, 5'd0);
        a_B = mk(19'h2A1B5, 5'd3, 5'd0);
        a_C = mk(19'h7FFF5, 5'd3, 5'd0);
        a_D = mk(19'h10005, 5'd3, 5'd0);
        look(a_A, 0, 0);
        fill(a_A, 0);
        look(a_A | 29'd7, 0, 0);
        look(a_B, 0, 0);
        fill(a_B, 1);
        look(a_B | 29'd31, 0, 0);
        look(a_A, 0, 0);
        // R8: copy-back marks A, write-through leaves B clean.
        look(a_A, 1, 1);
        look(a_B, 1, 0);
        look(a_C, 0, 0);   // R7: victim A dirty
        fill(a_C, 0);
        look(a_D, 1, 1);   // R7 R8: victim B clean, write miss
        idle();

        // R4: both ways carry the same tag.
        fill(mk(19'h0ABC1, 5'd7, 5'd0), 0);
        fill(mk(19'h0ABC1, 5'd7, 5'd0), 1);
        look(mk(19'h0ABC1, 5'd7, 5'd4), 0, 0);

        // R10: lookup and fill on the same set in one cycle.
        fill(mk(19'h00112, 5'd9, 5'd0), 0);
        op(1, mk(19'h00112, 5'd9, 5'd0), 0, 0, 1, mk(19'h33332, 5'd9, 5'd0), 1);
        op(1, mk(19'h44442, 5'd9, 5'd0), 0, 0, 1, mk(19'h44442, 5'd9, 5'd0), 0);
        look(mk(19'h44442, 5'd9, 5'd0), 0, 0);
        look(mk(19'h55552, 5'd9, 5'd0), 0, 0);
        // R10 R8: a fill wipes the mark of a same-cycle write hit.
        fill(mk(19'h01113, 5'd11, 5'd0), 0);
        op(1, mk(19'h01113, 5'd11, 5'd0), 1, 1, 1, mk(19'h02223, 5'd11, 5'd0), 0);
        fill(mk(19'h03333, 5'd11, 5'd0), 1);
        look(mk(19'h04443, 5'd11, 5'd0), 0, 0);

        // R5 R8: write miss in copy-back changes nothing.
        fill(mk(19'h11114, 5'd13, 5'd0), 0);
        look(mk(19'h22224, 5'd13, 5'd0), 1, 1);
        look(mk(19'h33334, 5'd13, 5'd0), 0, 0);
        fill(mk(19'h44444, 5'd13, 5'd0), 1);
        look(mk(19'h55554, 5'd13, 5'd0), 0, 0);

        // Boundary: set 511 with all-ones tag, set 0.
        fill(mk(19'h7FFFF, 5'd31, 5'd0), 1);
        look(mk(19'h7FFFF, 5'd31, 5'd31), 1, 1);
        look(mk(19'h0000F, 5'd31, 5'd0), 0, 0);
        fill(mk(19'h0000F, 5'd31, 5'd0), 0);
        look(mk(19'h1000F, 5'd31, 5'd0), 0, 0);
        fill(mk(19'h00000, 5'd0, 5'd0), 1);
        look(mk(19'h00000, 5'd0, 5'd0), 0, 0);

        // R12: manual reset keeps presence, mark and replacement state.
        fill(mk(19'h0AAA6, 5'd17, 5'd0), 0);
        look(mk(19'h0AAA6, 5'd17, 5'd0), 1, 1);
        do_man();
        look(mk(19'h0AAA6, 5'd17, 5'd0), 0, 0);
        look(mk(19'h0BBB6, 5'd17, 5'd0), 0, 0);
        fill(mk(19'h0CCC6, 5'd17, 5'd0), 1);
        look(mk(19'h0DDD6, 5'd17, 5'd0), 0, 0);

        // R11: power-on reset clears presence, marks and replacement bits.
        look(mk(19'h0CCC6, 5'd17, 5'd0), 0, 0);
        do_por();
        look(mk(19'h0AAA6, 5'd17, 5'd0), 0, 0);
        look(mk(19'h0CCC6, 5'd17, 5'd0), 0, 0);
        look(mk(19'h7FFFF, 5'd31, 5'd0), 0, 0);
        look(a_C, 0, 0);

        repeat (3) idle();
        chk("R1", "no outstanding lookups", expq.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule